// File: doc/BRIEF.md
# Write-Through Data Cache Store Merger

This block is the store side of a small direct-mapped, write-through data cache. Each cache entry holds one address tag, a valid bit for each of its longword slots, and the data of those slots. When the processor issues a store, the block finds the entry and slot that the store address maps to. It compares tags and merges the written bytes, in big-endian order, into a matching valid longword. The write to external memory happens elsewhere. This block only keeps the cached copy consistent with it.

A store may be misaligned. A long store at a nonzero byte offset, or a word store at offset 3, also writes the following longword at address plus four. That longword can belong to the next entry, and it gets its own tag check. A write-allocate control input sets the miss policy. With write-allocate set, a miss invalidates the slot it touched, and an aligned long store installs its data outright. With write-allocate clear, a miss leaves the cache untouched. A read-back port shows the tag, valid bits and data of any entry.

Top module: `dcache_store_merge`

## Requirements
- R1: A synchronous reset clears all tags, valid bits and data. While `flush_all` is high, `st_ready` is low, no store is accepted, and every valid bit is clear after the next clock edge.
- R2: An accepted store has no effect on the cache if `ctl_dc_enable` is low, if `st_cacheable` is low, or if `st_size` is 3. The size code is 0 for byte, 1 for word and 2 for long.
- R3: A longword hits when the entry tag equals address bits [31:8] and the slot's valid bit is set. The entry is chosen by address bits [7:4] and the slot by bits [3:2]. On a hit, the store bytes replace bytes starting at offset `st_addr[1:0]`, where byte 0 is bits 31:24. A word store supplies `st_data[15:0]` and a byte store supplies `st_data[7:0]`.
- R4: An enabled, cacheable long store at offset 0 with `ctl_write_alloc` high writes the tag, the data and the valid bit of its slot. It does so whatever the slot held before. If the new tag differs from the old one, the other slots of that entry become invalid.
- R5: A store to the first longword that misses clears that slot's valid bit when `ctl_write_alloc` is high. It changes nothing when `ctl_write_alloc` is low.
- R6: Only a long store at offset 1, 2 or 3, or a word store at offset 3, touches the longword at address plus four. Byte stores never touch it. Slot 3 of an entry continues into slot 0 of the next entry.
- R7: In the second longword, a long store at offset k writes the low k bytes of `st_data` into bytes 0 to k-1. A word store at offset 3 writes `st_data[7:0]` into byte 0. All other bytes of that longword are kept.
- R8: The second longword has its own tag and valid check. It is merged on a hit, invalidated on a miss when `ctl_write_alloc` is high, and left alone on a miss otherwise.
- R9: `st_ready` is high whenever `flush_all` is low. Both longword updates of an accepted store appear on the read-back port after exactly one clock edge. The cache does not change in a cycle with no accepted store and no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush_all | input | 1 | Invalidate every slot; blocks stores |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted |
| st_addr | input | 32 | Byte address of the store |
| st_data | input | 32 | Store value, right-justified |
| st_size | input | 2 | 0 byte, 1 word, 2 long, 3 reserved |
| st_cacheable | input | 1 | Store address is cacheable |
| ctl_dc_enable | input | 1 | Data cache enabled |
| ctl_write_alloc | input | 1 | Write-allocate miss policy |
| rd_index | input | 4 | Entry selected for read-back |
| rd_tag | output | 24 | Tag of the selected entry |
| rd_valid | output | 4 | Valid bits of the selected entry, bit n = slot n |
| rd_data | output | 128 | Slot n data at bits [32n+31:32n] |

## Verification
The bench focuses on misaligned stores. Long stores at every offset, and word stores at offset 3, must change exactly the right bytes of two longwords. If a shift amount is wrong, a neighbouring byte gets corrupted or a byte is missing on one side of the boundary. A store from slot 3 that crosses into the next entry checks that the entry index is carried. If it were not, the write would wrap into slot 0 of the same entry. Separate tag checks on the two halves are tested with the second half missing while the first hits. A design that shared one hit result would write stale data or would fail to invalidate. The bench also installs a new tag over an entry that still has valid slots. A design that skipped clearing those slots would leave them falsely valid under the new tag.

// File: rtl/dcsm_pkg.sv
`timescale 1ns/1ps
package dcsm_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } st_size_e;

    // keep: bits of the old longword that survive; ins: bits written in
    typedef struct packed {
        logic [31:0] keep;
        logic [31:0] ins;
    } lane_mask_t;

endpackage

// File: rtl/dcsm_lane_mask.sv
`timescale 1ns/1ps
module dcsm_lane_mask
    import dcsm_pkg::*;
#(
    parameter bit SECOND = 1'b0
) (
    input  st_size_e    size,
    input  logic [1:0]  off,
    input  logic [31:0] val,
    output lane_mask_t  mask
);

    logic [4:0] sh;
    assign sh = {off, 3'b000};

    generate
        if (!SECOND) begin : g_first
            always_comb begin
                mask.keep = 32'hFFFF_FFFF;
                mask.ins  = 32'h0;
                case (size)
                    SZ_BYTE: begin
                        mask.keep = ~(32'hFF00_0000 >> sh);
                        mask.ins  = (val << 24) >> sh;
                    end
                    SZ_WORD: begin
                        mask.keep = ~(32'hFFFF_0000 >> sh);
                        mask.ins  = (val << 16) >> sh;
                    end
                    SZ_LONG: begin
                        mask.keep = ~(32'hFFFF_FFFF >> sh);
                        mask.ins  = val >> sh;
                    end
                    default: ;
                endcase
            end
        end else begin : g_second
            logic [5:0] lsh;
            assign lsh = 6'd32 - {1'b0, sh};
            always_comb begin
                mask.keep = 32'hFFFF_FFFF;
                mask.ins  = 32'h0;
                case (size)
                    SZ_LONG: begin
                        mask.keep = 32'hFFFF_FFFF >> sh;
                        mask.ins  = val << lsh;
                    end
                    SZ_WORD: begin
                        mask.keep = 32'h00FF_FFFF;
                        mask.ins  = val << 24;
                    end
                    default: ;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/dcsm_locate.sv
`timescale 1ns/1ps
module dcsm_locate
    import dcsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int SLOT_W = 2,
    localparam int TAG_W = ADDR_W - IDX_W - SLOT_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  st_size_e          size,
    output logic [IDX_W-1:0]  idx0,
    output logic [SLOT_W-1:0] slot0,
    output logic [TAG_W-1:0]  tag0,
    output logic [IDX_W-1:0]  idx1,
    output logic [SLOT_W-1:0] slot1,
    output logic [TAG_W-1:0]  tag1,
    output logic              touch1,
    output logic              aligned_long
);

    localparam int LW_W = ADDR_W - 2;

    logic [LW_W-1:0] lw0, lw1;

    assign lw0 = addr[ADDR_W-1:2];
    assign lw1 = lw0 + LW_W'(1);

    assign slot0 = lw0[SLOT_W-1:0];
    assign idx0  = lw0[SLOT_W+IDX_W-1:SLOT_W];
    assign tag0  = lw0[LW_W-1:SLOT_W+IDX_W];
    assign slot1 = lw1[SLOT_W-1:0];
    assign idx1  = lw1[SLOT_W+IDX_W-1:SLOT_W];
    assign tag1  = lw1[LW_W-1:SLOT_W+IDX_W];

    assign touch1 = ((size == SZ_LONG) && (addr[1:0] != 2'd0)) ||
                    ((size == SZ_WORD) && (addr[1:0] == 2'd3));
    assign aligned_long = (size == SZ_LONG) && (addr[1:0] == 2'd0);

endmodule

// File: rtl/dcache_store_merge.sv
`timescale 1ns/1ps
module dcache_store_merge
    import dcsm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int LINE_LW = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int SLOT_W = $clog2(LINE_LW),
    localparam int TAG_W  = ADDR_W - IDX_W - SLOT_W - 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush_all,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [ADDR_W-1:0]     st_addr,
    input  logic [31:0]           st_data,
    input  logic [1:0]            st_size,
    input  logic                  st_cacheable,
    input  logic                  ctl_dc_enable,
    input  logic                  ctl_write_alloc,
    input  logic [IDX_W-1:0]      rd_index,
    output logic [TAG_W-1:0]      rd_tag,
    output logic [LINE_LW-1:0]    rd_valid,
    output logic [LINE_LW*32-1:0] rd_data
);

    localparam int NLANE = 2;

    typedef struct packed {
        logic [ENTRIES-1:0][TAG_W-1:0]         tag;
        logic [ENTRIES-1:0][LINE_LW-1:0]       valid;
        logic [ENTRIES-1:0][LINE_LW-1:0][31:0] data;
    } state_t;

    state_t st_d, st_q;

    st_size_e size_e;
    assign size_e = st_size_e'(st_size);

    logic [IDX_W-1:0]  idx0, idx1;
    logic [SLOT_W-1:0] slot0, slot1;
    logic [TAG_W-1:0]  tag0, tag1;
    logic              touch1, aligned_long;

    dcsm_locate #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .SLOT_W (SLOT_W)
    ) u_locate (
        .addr         (st_addr),
        .size         (size_e),
        .idx0         (idx0),
        .slot0        (slot0),
        .tag0         (tag0),
        .idx1         (idx1),
        .slot1        (slot1),
        .tag1         (tag1),
        .touch1       (touch1),
        .aligned_long (aligned_long)
    );

    lane_mask_t       lane_mask [NLANE];
    logic [IDX_W-1:0]  lane_idx  [NLANE];
    logic [SLOT_W-1:0] lane_slot [NLANE];
    logic [TAG_W-1:0]  lane_tag  [NLANE];
    logic              lane_on   [NLANE];

    assign lane_idx[0]  = idx0;
    assign lane_slot[0] = slot0;
    assign lane_tag[0]  = tag0;
    assign lane_on[0]   = 1'b1;
    assign lane_idx[1]  = idx1;
    assign lane_slot[1] = slot1;
    assign lane_tag[1]  = tag1;
    assign lane_on[1]   = touch1;

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            dcsm_lane_mask #(
                .SECOND (g != 0)
            ) u_mask (
                .size (size_e),
                .off  (st_addr[1:0]),
                .val  (st_data),
                .mask (lane_mask[g])
            );
        end
    endgenerate

    logic accept, effective;

    assign st_ready  = ~flush_all;
    assign accept    = st_valid & st_ready;
    assign effective = accept & ctl_dc_enable & st_cacheable & (size_e != SZ_RSVD);

    always_comb begin
        logic hit;
        st_d = st_q;
        hit  = 1'b0;
        if (flush_all) begin
            st_d.valid = '0;
        end else if (effective) begin
            if (aligned_long && ctl_write_alloc) begin
                if (st_q.tag[idx0] != tag0) begin
                    st_d.valid[idx0] = '0;
                end
                st_d.tag[idx0]          = tag0;
                st_d.valid[idx0][slot0] = 1'b1;
                st_d.data[idx0][slot0]  = st_data;
            end else begin
                for (int l = 0; l < NLANE; l++) begin
                    if (lane_on[l]) begin
                        hit = (st_q.tag[lane_idx[l]] == lane_tag[l]) &&
                              st_q.valid[lane_idx[l]][lane_slot[l]];
                        if (hit) begin
                            st_d.data[lane_idx[l]][lane_slot[l]] =
                                (st_q.data[lane_idx[l]][lane_slot[l]] & lane_mask[l].keep) |
                                lane_mask[l].ins;
                        end else if (ctl_write_alloc) begin
                            st_d.valid[lane_idx[l]][lane_slot[l]] = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [ENTRIES*TAG_W-1:0]        tag_flat;
    logic [ENTRIES*LINE_LW-1:0]      valid_flat;
    logic [ENTRIES*LINE_LW*32-1:0]   data_flat;

    assign tag_flat   = st_q.tag;
    assign valid_flat = st_q.valid;
    assign data_flat  = st_q.data;

    assign rd_tag   = tag_flat[rd_index*TAG_W +: TAG_W];
    assign rd_valid = valid_flat[rd_index*LINE_LW +: LINE_LW];
    assign rd_data  = data_flat[rd_index*LINE_LW*32 +: LINE_LW*32];

endmodule

// File: rtl/dcsm_checker.sv
`timescale 1ns/1ps
module dcsm_checker #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int LINE_LW = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int SLOT_W = $clog2(LINE_LW),
    localparam int TAG_W  = ADDR_W - IDX_W - SLOT_W - 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        flush_all,
    input logic                        st_valid,
    input logic                        st_ready,
    input logic [ADDR_W-1:0]           st_addr,
    input logic [1:0]                  st_size,
    input logic                        st_cacheable,
    input logic                        ctl_dc_enable,
    input logic                        ctl_write_alloc,
    input logic [ENTRIES*TAG_W-1:0]    tag_flat,
    input logic [ENTRIES*LINE_LW-1:0]  valid_flat,
    input logic [ENTRIES*LINE_LW*32-1:0] data_flat
);

    logic [IDX_W+SLOT_W-1:0] pos;
    logic                    acc;
    assign pos = st_addr[IDX_W+SLOT_W+1:2];
    assign acc = st_valid && st_ready;

    // R1: flush leaves no valid slot behind
    p_flush_clears_r1: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (valid_flat == '0));

    // R2: disabled or uncacheable stores leave the cache alone
    p_disabled_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (acc && (!ctl_dc_enable || !st_cacheable)) |=>
        ($stable(valid_flat) && $stable(tag_flat) && $stable(data_flat)));

    // R4: allocating aligned long store leaves its slot valid
    p_install_valid_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && ctl_dc_enable && st_cacheable && ctl_write_alloc &&
         st_size == 2'd2 && st_addr[1:0] == 2'd0) |=> valid_flat[$past(pos)]);

    // R5: without write-allocate no valid bit is ever set
    p_no_alloc_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && !ctl_write_alloc) |=> ((valid_flat & ~$past(valid_flat)) == '0));

    // R6: a byte store changes at most one valid bit
    p_byte_one_slot_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && st_size == 2'd0) |=> ($countones(valid_flat ^ $past(valid_flat)) <= 1));

    // R9: idle cycles keep the state
    p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (!st_valid && !flush_all) |=>
        ($stable(valid_flat) && $stable(tag_flat) && $stable(data_flat)));

endmodule

bind dcache_store_merge dcsm_checker #(
    .ADDR_W  (ADDR_W),
    .ENTRIES (ENTRIES),
    .LINE_LW (LINE_LW)
) u_dcsm_checker (
    .clk             (clk),
    .rst             (rst),
    .flush_all       (flush_all),
    .st_valid        (st_valid),
    .st_ready        (st_ready),
    .st_addr         (st_addr),
    .st_size         (st_size),
    .st_cacheable    (st_cacheable),
    .ctl_dc_enable   (ctl_dc_enable),
    .ctl_write_alloc (ctl_write_alloc),
    .tag_flat        (tag_flat),
    .valid_flat      (valid_flat),
    .data_flat       (data_flat)
);

// File: tb/tb_dcache_store_merge.sv
`timescale 1ns/100ps
module tb_dcache_store_merge;

    logic         clk = 1'b0;
    logic         rst;
    logic         flush_all;
    logic         st_valid;
    logic         st_ready;
    logic [31:0]  st_addr;
    logic [31:0]  st_data;
    logic [1:0]   st_size;
    logic         st_cacheable;
    logic         ctl_dc_enable;
    logic         ctl_write_alloc;
    logic [3:0]   rd_index;
    logic [23:0]  rd_tag;
    logic [3:0]   rd_valid;
    logic [127:0] rd_data;

    always #4 clk = ~clk;

    dcache_store_merge dut (
        .clk             (clk),
        .rst             (rst),
        .flush_all       (flush_all),
        .st_valid        (st_valid),
        .st_ready        (st_ready),
        .st_addr         (st_addr),
        .st_data         (st_data),
        .st_size         (st_size),
        .st_cacheable    (st_cacheable),
        .ctl_dc_enable   (ctl_dc_enable),
        .ctl_write_alloc (ctl_write_alloc),
        .rd_index        (rd_index),
        .rd_tag          (rd_tag),
        .rd_valid        (rd_valid),
        .rd_data         (rd_data)
    );

    bit [23:0] m_tag [16];
    bit        m_val [16][4];
    bit [31:0] m_dat [16][4];

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string cur   = "R1";

    function automatic void model_clear_all();
        for (int e = 0; e < 16; e++) begin
            m_tag[e] = '0;
            for (int s = 0; s < 4; s++) begin
                m_val[e][s] = 1'b0;
                m_dat[e][s] = '0;
            end
        end
    endfunction

    // byte-oriented reference: each store is a run of bytes at a, a+1, ...
    function automatic void model_store(bit [31:0] a, bit [31:0] v, bit [1:0] sz,
                                        bit c, bit en, bit wa);
        int        n;
        bit [31:0] la, ba;
        bit        any, hit;
        int        e, s;
        if (!en || !c || sz == 2'd3) return;
        n = 1 << sz;
        if (sz == 2'd2 && a[1:0] == 2'd0 && wa) begin
            e = int'(a[7:4]);
            s = int'(a[3:2]);
            if (m_tag[e] != a[31:8])
                for (int k = 0; k < 4; k++) m_val[e][k] = 1'b0;
            m_tag[e]    = a[31:8];
            m_val[e][s] = 1'b1;
            m_dat[e][s] = v;
            return;
        end
        for (int q = 0; q < 2; q++) begin
            la  = {a[31:2], 2'b00} + 32'(4 * q);
            any = 1'b0;
            for (int k = 0; k < n; k++) begin
                ba = a + 32'(k);
                if ({ba[31:2], 2'b00} == la) any = 1'b1;
            end
            if (any) begin
                e   = int'(la[7:4]);
                s   = int'(la[3:2]);
                hit = (m_tag[e] == la[31:8]) && m_val[e][s];
                if (hit) begin
                    for (int k = 0; k < n; k++) begin
                        ba = a + 32'(k);
                        if ({ba[31:2], 2'b00} == la)
                            m_dat[e][s][(3 - int'(ba[1:0])) * 8 +: 8] = v[(n - 1 - k) * 8 +: 8];
                    end
                end else if (wa) begin
                    m_val[e][s] = 1'b0;
                end
            end
        end
    endfunction

    task automatic compare_all();
        bit [3:0] mv;
        bit       ok;
        ok = 1'b1;
        for (int e = 0; e < 16 && ok; e++) begin
            rd_index = e[3:0];
            #0.1;
            for (int s = 0; s < 4; s++) mv[s] = m_val[e][s];
            if (rd_tag !== m_tag[e] || rd_valid !== mv ||
                rd_data !== {m_dat[e][3], m_dat[e][2], m_dat[e][1], m_dat[e][0]}) begin
                ok = 1'b0;
                $display("FAIL %s entry %0d: tag %h valid %b data %h, expected tag %h valid %b data %h",
                         cur, e, rd_tag, rd_valid, rd_data, m_tag[e], mv,
                         {m_dat[e][3], m_dat[e][2], m_dat[e][1], m_dat[e][0]});
            end
        end
        total++;
        if (!ok) bad++;
    endtask

    task automatic check_lw(bit [31:0] a, bit exp_v, bit [31:0] exp_d, string req);
        rd_index = a[7:4];
        #0.1;
        total++;
        if (rd_valid[a[3:2]] !== exp_v || (exp_v && rd_data[a[3:2]*32 +: 32] !== exp_d)) begin
            bad++;
            $display("FAIL %s longword %h: valid %b data %h, expected valid %b data %h",
                     req, a, rd_valid[a[3:2]], rd_data[a[3:2]*32 +: 32], exp_v, exp_d);
        end
    endtask

    // called just after a falling edge; returns just after the next falling edge
    task automatic store(bit [31:0] a, bit [31:0] v, bit [1:0] sz, bit c, bit en, bit wa,
                         string req);
        cur             = req;
        st_addr         = a;
        st_data         = v;
        st_size         = sz;
        st_cacheable    = c;
        ctl_dc_enable   = en;
        ctl_write_alloc = wa;
        st_valid        = 1'b1;
        @(posedge clk);
        #1;
        model_store(a, v, sz, c, en, wa);
        st_valid = 1'b0;
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired during %s", cur);
        finish_run();
    end

    initial begin
        rst = 1'b1; flush_all = 1'b0; st_valid = 1'b0;
        st_addr = '0; st_data = '0; st_size = '0;
        st_cacheable = 1'b1; ctl_dc_enable = 1'b1; ctl_write_alloc = 1'b1;
        rd_index = '0;
        model_clear_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur = "R1";
        compare_all();                                      // R1 reset state
        total++;
        if (st_ready !== 1'b1) begin bad++; $display("FAIL R9 st_ready %b expected 1", st_ready); end

        // R4 install, R3 hit merges
        store(32'h100, 32'h11223344, 2, 1, 1, 1, "R4");
        check_lw(32'h100, 1, 32'h11223344, "R4");
        store(32'h101, 32'h000000AA, 0, 1, 1, 0, "R3");
        check_lw(32'h100, 1, 32'h11AA3344, "R3");
        store(32'h102, 32'h0000BEEF, 1, 1, 1, 0, "R3");
        check_lw(32'h100, 1, 32'h11AABEEF, "R3");
        store(32'h104, 32'h55667788, 2, 1, 1, 1, "R4");
        // R7 long straddle at offset 3 within one entry
        store(32'h103, 32'hA1B2C3D4, 2, 1, 1, 0, "R7");
        check_lw(32'h100, 1, 32'h11AABEA1, "R7");
        check_lw(32'h104, 1, 32'hB2C3D488, "R7");
        // R7 word at offset 3
        store(32'h103, 32'h00001234, 1, 1, 1, 1, "R7");
        check_lw(32'h100, 1, 32'h11AABE12, "R7");
        check_lw(32'h104, 1, 32'h34C3D488, "R7");
        // R2 ignored stores
        store(32'h100, 32'hFFFFFFFF, 2, 1, 0, 1, "R2");
        store(32'h104, 32'hFFFFFFFF, 2, 0, 1, 1, "R2");
        store(32'h100, 32'hFFFFFFFF, 3, 1, 1, 1, "R2");
        check_lw(32'h100, 1, 32'h11AABE12, "R2");
        check_lw(32'h104, 1, 32'h34C3D488, "R2");
        // R5 miss policy
        store(32'h205, 32'h0000CCDD, 1, 1, 1, 0, "R5");
        check_lw(32'h104, 1, 32'h34C3D488, "R5");
        store(32'h201, 32'h00000077, 0, 1, 1, 1, "R5");
        check_lw(32'h100, 0, 32'h0, "R5");
        check_lw(32'h104, 1, 32'h34C3D488, "R5");
        // R4 new tag clears the rest of the entry
        store(32'h200, 32'h0BADF00D, 2, 1, 1, 1, "R4");
        check_lw(32'h200, 1, 32'h0BADF00D, "R4");
        check_lw(32'h204, 0, 32'h0, "R4");
        // R6 crossing from slot 3 into the next entry
        store(32'h13C, 32'hCAFEF00D, 2, 1, 1, 1, "R6");
        store(32'h140, 32'h01020304, 2, 1, 1, 1, "R6");
        store(32'h13E, 32'hDEADBEEF, 2, 1, 1, 0, "R6");
        check_lw(32'h13C, 1, 32'hCAFEDEAD, "R6");
        check_lw(32'h140, 1, 32'hBEEF0304, "R6");
        store(32'h13F, 32'h00000055, 0, 1, 1, 0, "R6");
        check_lw(32'h13C, 1, 32'hCAFEDE55, "R6");
        check_lw(32'h140, 1, 32'hBEEF0304, "R6");
        // R8 second half misses while the first hits
        store(32'h240, 32'h00000001, 0, 1, 1, 1, "R8");
        store(32'h13F, 32'h99887766, 2, 1, 1, 1, "R8");
        check_lw(32'h13C, 1, 32'hCAFEDE99, "R8");
        check_lw(32'h140, 0, 32'h0, "R8");
        store(32'h144, 32'hAAAAAAAA, 2, 1, 1, 1, "R8");
        store(32'h242, 32'h12345678, 2, 1, 1, 1, "R8");
        check_lw(32'h144, 0, 32'h0, "R8");
        // address space wrap
        store(32'hFFFFFFFC, 32'h10203040, 2, 1, 1, 1, "R6");
        store(32'h00000000, 32'h50607080, 2, 1, 1, 1, "R6");
        store(32'hFFFFFFFE, 32'hA0B0C0D0, 2, 1, 1, 0, "R6");
        check_lw(32'hFFFFFFFC, 1, 32'h1020A0B0, "R6");
        check_lw(32'h00000000, 1, 32'hC0D07080, "R6");

        // random mix, compared against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            bit [31:0] a;
            bit [1:0]  sz;
            a  = {22'd0, 10'($urandom_range(0, 767))};
            if ($urandom_range(0, 31) == 0) a = 32'hFFFFFF00 | 32'($urandom_range(0, 255));
            sz = ($urandom_range(0, 19) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
            store(a, $urandom, sz, $urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
                  $urandom_range(0, 1) == 1, "R3");
        end

        // R1 flush blocks a simultaneous store and clears valid bits
        cur = "R1";
        flush_all = 1'b1;
        st_valid = 1'b1; st_addr = 32'h100; st_size = 2; st_data = 32'h1;
        ctl_dc_enable = 1'b1; st_cacheable = 1'b1; ctl_write_alloc = 1'b1;
        #0.5;
        total++;
        if (st_ready !== 1'b0) begin bad++; $display("FAIL R1 st_ready %b expected 0", st_ready); end
        @(posedge clk);
        #1;
        for (int e = 0; e < 16; e++)
            for (int s = 0; s < 4; s++) m_val[e][s] = 1'b0;
        flush_all = 1'b0; st_valid = 1'b0;
        @(negedge clk);
        compare_all();
        total++;
        if (st_ready !== 1'b1) begin bad++; $display("FAIL R9 st_ready %b expected 1", st_ready); end

        for (int i = 0; i < 500; i++) begin
            store({22'd0, 10'($urandom_range(0, 511))}, $urandom, 2'($urandom_range(0, 2)),
                  1, 1, $urandom_range(0, 3) != 0, "R8");
        end

        // R9 idle cycles change nothing
        cur = "R9";
        repeat (4) begin
            @(negedge clk);
            compare_all();
        end
        finish_run();
    end

endmodule